// File: doc/BRIEF.md
# Per-Port VLAN Tag Controller

This block makes the VLAN decisions for each frame crossing a five-port switch. For every frame it receives a descriptor: whether the frame already carries a tag, the tag's VLAN ID, the port it arrived on and the port it leaves by. From these it decides three things:

- whether to push the ingress port's default VLAN ID as a new tag;
- whether the frame fails the membership check and must be discarded;
- whether the egress side removes the outermost tag.

The frame bytes themselves are edited elsewhere. This block only produces the per-frame verdict.

The block owns its per-port configuration registers, which are loaded through a simple write port. It consults an external VLAN table in a two-stage pipeline:

1. One cycle after a descriptor is accepted, the block presents the effective VLAN ID on a lookup output.
2. The table answers combinationally in that same cycle with a hit flag, a membership mask and a tag mask.
3. One cycle later the block presents the registered verdict.

Top module: `vtc_port_tagger`

## Requirements
- R1: After reset every configuration register reads as zero in behaviour (no insertion, egress mode 0, no filtering) and neither `lk_valid` nor `rs_valid` is high.
- R2: A descriptor accepted with `fr_valid` high gives `lk_valid` one cycle later and `rs_valid` two cycles later, one result per descriptor, in order, also back to back.
- R3: When the ingress port's 2-bit field at bits [2p+1:2p] of address 0x00 holds 2 (tag-always) and bit p of address 0x08 is set, `rs_insert` is high and `rs_vid` equals bits [11:0] of that port's default-ID register at address 0x40+4p, whether or not the frame was tagged already.
- R4: With ingress field 2 and bit p of 0x08 clear, or with ingress field 0, 1 or 3 whatever bit p of 0x08 holds, no tag is inserted.
- R5: The lookup VLAN ID (`lk_vid`, echoed on `rs_vid`) is the inserted default ID when a tag is inserted, else the frame's own VLAN ID for a tagged frame, else 0.
- R6: Egress field [2q+1:2q] of address 0x04 for egress port q: values 0 (disabled) and 2 (tag-through) never strip.
- R7: Egress value 1 strips whenever the frame carries a tag after ingress (its own or an inserted one), and never for a frame left untagged.
- R8: Egress value 3 (transparent) strips only when the table hits and bit q of the tag mask is clear; on a hit with the bit set, or on a miss, it does not strip.
- R9: With both bit p (verify) and bit 8+p (discard) of address 0x0C set for the ingress port, the frame is dropped when it has no tag after ingress, misses in the table, or bit p of the membership mask is clear.
- R10: With only one of the verify or discard bits set, no frame is dropped.
- R11: A dropped frame has `rs_insert` and `rs_strip` low.
- R12: Writes to addresses other than 0x00, 0x04, 0x08, 0x0C and 0x40+4p for existing ports change no behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| fr_valid | input | 1 | Frame descriptor valid |
| fr_tagged | input | 1 | Frame arrives with a VLAN tag |
| fr_vid | input | 12 | VLAN ID of the arriving tag |
| fr_in_port | input | 3 | Ingress port number |
| fr_out_port | input | 3 | Egress port number |
| lk_valid | output | 1 | Lookup request valid |
| lk_vid | output | 12 | Effective VLAN ID to look up |
| tb_hit | input | 1 | Table lookup hit for `lk_vid` |
| tb_member | input | 5 | Membership mask of the hit entry |
| tb_tagmask | input | 5 | Tag mask of the hit entry |
| rs_valid | output | 1 | Verdict valid |
| rs_insert | output | 1 | Push a tag carrying `rs_vid` |
| rs_vid | output | 12 | Effective VLAN ID of the frame |
| rs_strip | output | 1 | Remove the outermost tag on egress |
| rs_drop | output | 1 | Discard the frame |

## Verification
The bench builds the block with its default parameters: five ports, a 3-bit port number, 12-bit VLAN IDs and an 8-bit address. With these values every port's default-ID register, ingress and egress field, and verify and discard bit pair can be reached and set to a distinct setting within a single run. The table model holds four entries whose membership and tag masks differ per port, so hit, miss, member and non-member cases all arise on the same ports. Configurations mixing all four egress modes and several filter combinations are then exercised with single and back-to-back descriptors.

// File: rtl/vtc_pkg.sv
`timescale 1ns/1ps
package vtc_pkg;
  typedef enum logic [1:0] {
    IN_OFF        = 2'd0,
    IN_RSV1       = 2'd1,
    IN_TAG_ALWAYS = 2'd2,
    IN_RSV3       = 2'd3
  } in_mode_e;

  typedef enum logic [1:0] {
    EG_OFF     = 2'd0,
    EG_STRIP   = 2'd1,
    EG_THROUGH = 2'd2,
    EG_TRANSP  = 2'd3
  } eg_mode_e;

  // configuration byte addresses
  localparam int A_IN_MODE   = 'h00;
  localparam int A_EG_MODE   = 'h04;
  localparam int A_IN_EN     = 'h08;
  localparam int A_FILTER    = 'h0C;
  localparam int A_PVID_BASE = 'h40;
  localparam int PVID_STRIDE = 4;
  // bit offset of the discard bits inside the filter register
  localparam int DISC_OFS    = 8;
endpackage

// File: rtl/vtc_cfg_regs.sv
`timescale 1ns/1ps
module vtc_cfg_regs
  import vtc_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int PW     = 3,
  parameter int VID_W  = 12,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [DW-1:0]                    wdata_i,
  output logic [(1<<PW)-1:0][1:0]          in_mode_o,
  output logic [(1<<PW)-1:0][1:0]          eg_mode_o,
  output logic [(1<<PW)-1:0]               in_en_o,
  output logic [(1<<PW)-1:0]               verify_o,
  output logic [(1<<PW)-1:0]               discard_o,
  output logic [(1<<PW)-1:0][VID_W-1:0]    pvid_o
);
  localparam int SLOTS = 1 << PW;

  logic [NPORTS-1:0][1:0]       in_mode_q, eg_mode_q;
  logic [NPORTS-1:0]            in_en_q, verify_q, discard_q;
  logic [NPORTS-1:0][VID_W-1:0] pvid_q;
  logic                         unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_mode_q <= '0;
      eg_mode_q <= '0;
      in_en_q   <= '0;
      verify_q  <= '0;
      discard_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(A_IN_MODE))
        in_mode_q <= wdata_i[2*NPORTS-1:0];
      else if (addr_i == AW'(A_EG_MODE))
        eg_mode_q <= wdata_i[2*NPORTS-1:0];
      else if (addr_i == AW'(A_IN_EN))
        in_en_q <= wdata_i[NPORTS-1:0];
      else if (addr_i == AW'(A_FILTER)) begin
        verify_q  <= wdata_i[NPORTS-1:0];
        discard_q <= wdata_i[DISC_OFS +: NPORTS];
      end
    end
  end

  // one default-ID register per port
  for (genvar p = 0; p < NPORTS; p++) begin : g_pvid
    localparam logic [AW-1:0] PADDR = AW'(A_PVID_BASE + PVID_STRIDE * p);
    always_ff @(posedge clk) begin
      if (rst)
        pvid_q[p] <= '0;
      else if (we_i && addr_i == PADDR)
        pvid_q[p] <= wdata_i[VID_W-1:0];
    end
  end

  // pad to the full port-number range; missing ports read as zero
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NPORTS) begin : g_real
      assign in_mode_o[s] = in_mode_q[s];
      assign eg_mode_o[s] = eg_mode_q[s];
      assign in_en_o[s]   = in_en_q[s];
      assign verify_o[s]  = verify_q[s];
      assign discard_o[s] = discard_q[s];
      assign pvid_o[s]    = pvid_q[s];
    end else begin : g_pad
      assign in_mode_o[s] = '0;
      assign eg_mode_o[s] = '0;
      assign in_en_o[s]   = 1'b0;
      assign verify_o[s]  = 1'b0;
      assign discard_o[s] = 1'b0;
      assign pvid_o[s]    = '0;
    end
  end
endmodule

// File: rtl/vtc_ingress.sv
`timescale 1ns/1ps
module vtc_ingress
  import vtc_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int PW     = 3,
  parameter int VID_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fr_valid_i,
  input  logic                          fr_tagged_i,
  input  logic [VID_W-1:0]              fr_vid_i,
  input  logic [PW-1:0]                 fr_in_port_i,
  input  logic [PW-1:0]                 fr_out_port_i,
  input  logic [(1<<PW)-1:0][1:0]       in_mode_i,
  input  logic [(1<<PW)-1:0]            in_en_i,
  input  logic [(1<<PW)-1:0][VID_W-1:0] pvid_i,
  output logic                          lk_valid_o,
  output logic [VID_W-1:0]              lk_vid_o,
  output logic                          lk_ins_o,
  output logic                          lk_tag_o,
  output logic [PW-1:0]                 lk_in_port_o,
  output logic [PW-1:0]                 lk_out_port_o
);
  logic             ins_c;
  logic [VID_W-1:0] evid_c;

  always_comb begin
    ins_c = (in_mode_i[fr_in_port_i] == IN_TAG_ALWAYS) && in_en_i[fr_in_port_i];
    if (ins_c)
      evid_c = pvid_i[fr_in_port_i];
    else if (fr_tagged_i)
      evid_c = fr_vid_i;
    else
      evid_c = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid_o    <= 1'b0;
      lk_vid_o      <= '0;
      lk_ins_o      <= 1'b0;
      lk_tag_o      <= 1'b0;
      lk_in_port_o  <= '0;
      lk_out_port_o <= '0;
    end else begin
      lk_valid_o    <= fr_valid_i;
      lk_vid_o      <= evid_c;
      lk_ins_o      <= fr_valid_i && ins_c;
      lk_tag_o      <= fr_valid_i && (ins_c || fr_tagged_i);
      lk_in_port_o  <= fr_in_port_i;
      lk_out_port_o <= fr_out_port_i;
    end
  end
endmodule

// File: rtl/vtc_egress.sv
`timescale 1ns/1ps
module vtc_egress
  import vtc_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int PW     = 3,
  parameter int VID_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid_i,
  input  logic [VID_W-1:0]        lk_vid_i,
  input  logic                    lk_ins_i,
  input  logic                    lk_tag_i,
  input  logic [PW-1:0]           lk_in_port_i,
  input  logic [PW-1:0]           lk_out_port_i,
  input  logic                    tb_hit_i,
  input  logic [NPORTS-1:0]       tb_member_i,
  input  logic [NPORTS-1:0]       tb_tagmask_i,
  input  logic [(1<<PW)-1:0][1:0] eg_mode_i,
  input  logic [(1<<PW)-1:0]      verify_i,
  input  logic [(1<<PW)-1:0]      discard_i,
  output logic                    rs_valid_o,
  output logic                    rs_insert_o,
  output logic [VID_W-1:0]        rs_vid_o,
  output logic                    rs_strip_o,
  output logic                    rs_drop_o
);
  localparam int SLOTS = 1 << PW;

  logic [SLOTS-1:0] mem_x, tag_x;
  logic             hit_c, filt_c, drop_c, strip_c;

  assign mem_x = SLOTS'(tb_member_i);
  assign tag_x = SLOTS'(tb_tagmask_i);

  always_comb begin
    hit_c  = tb_hit_i && lk_tag_i;
    filt_c = verify_i[lk_in_port_i] && discard_i[lk_in_port_i];
    drop_c = filt_c && (!lk_tag_i || !tb_hit_i || !mem_x[lk_in_port_i]);
    case (eg_mode_e'(eg_mode_i[lk_out_port_i]))
      EG_STRIP:  strip_c = lk_tag_i;
      EG_TRANSP: strip_c = hit_c && !tag_x[lk_out_port_i];
      default:   strip_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid_o  <= 1'b0;
      rs_insert_o <= 1'b0;
      rs_vid_o    <= '0;
      rs_strip_o  <= 1'b0;
      rs_drop_o   <= 1'b0;
    end else begin
      rs_valid_o  <= lk_valid_i;
      rs_insert_o <= lk_valid_i && lk_ins_i && !drop_c;
      rs_vid_o    <= lk_vid_i;
      rs_strip_o  <= lk_valid_i && strip_c && !drop_c;
      rs_drop_o   <= lk_valid_i && drop_c;
    end
  end
endmodule

// File: rtl/vtc_port_tagger.sv
`timescale 1ns/1ps
module vtc_port_tagger #(
  parameter int NPORTS = 5,
  parameter int PW     = 3,
  parameter int VID_W  = 12,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              fr_valid,
  input  logic              fr_tagged,
  input  logic [VID_W-1:0]  fr_vid,
  input  logic [PW-1:0]     fr_in_port,
  input  logic [PW-1:0]     fr_out_port,
  output logic              lk_valid,
  output logic [VID_W-1:0]  lk_vid,
  input  logic              tb_hit,
  input  logic [NPORTS-1:0] tb_member,
  input  logic [NPORTS-1:0] tb_tagmask,
  output logic              rs_valid,
  output logic              rs_insert,
  output logic [VID_W-1:0]  rs_vid,
  output logic              rs_strip,
  output logic              rs_drop
);
  localparam int SLOTS = 1 << PW;

  logic [SLOTS-1:0][1:0]       in_mode, eg_mode;
  logic [SLOTS-1:0]            in_en, verify, discard;
  logic [SLOTS-1:0][VID_W-1:0] pvid;
  logic                        lk_ins, lk_tag;
  logic [PW-1:0]               lk_in_port, lk_out_port;

  vtc_cfg_regs #(.NPORTS(NPORTS), .PW(PW), .VID_W(VID_W), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .in_mode_o(in_mode), .eg_mode_o(eg_mode), .in_en_o(in_en),
    .verify_o(verify), .discard_o(discard), .pvid_o(pvid)
  );

  vtc_ingress #(.NPORTS(NPORTS), .PW(PW), .VID_W(VID_W)) u_ing (
    .clk(clk), .rst(rst),
    .fr_valid_i(fr_valid), .fr_tagged_i(fr_tagged), .fr_vid_i(fr_vid),
    .fr_in_port_i(fr_in_port), .fr_out_port_i(fr_out_port),
    .in_mode_i(in_mode), .in_en_i(in_en), .pvid_i(pvid),
    .lk_valid_o(lk_valid), .lk_vid_o(lk_vid), .lk_ins_o(lk_ins), .lk_tag_o(lk_tag),
    .lk_in_port_o(lk_in_port), .lk_out_port_o(lk_out_port)
  );

  vtc_egress #(.NPORTS(NPORTS), .PW(PW), .VID_W(VID_W)) u_egr (
    .clk(clk), .rst(rst),
    .lk_valid_i(lk_valid), .lk_vid_i(lk_vid), .lk_ins_i(lk_ins), .lk_tag_i(lk_tag),
    .lk_in_port_i(lk_in_port), .lk_out_port_i(lk_out_port),
    .tb_hit_i(tb_hit), .tb_member_i(tb_member), .tb_tagmask_i(tb_tagmask),
    .eg_mode_i(eg_mode), .verify_i(verify), .discard_i(discard),
    .rs_valid_o(rs_valid), .rs_insert_o(rs_insert), .rs_vid_o(rs_vid),
    .rs_strip_o(rs_strip), .rs_drop_o(rs_drop)
  );
endmodule

// File: rtl/vtc_port_tagger_chk.sv
`timescale 1ns/1ps
module vtc_port_tagger_chk #(
  parameter int NPORTS = 5,
  parameter int PW     = 3,
  parameter int VID_W  = 12,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [DW-1:0]     cfg_wdata,
  input logic              fr_valid,
  input logic              fr_tagged,
  input logic [VID_W-1:0]  fr_vid,
  input logic [PW-1:0]     fr_in_port,
  input logic [PW-1:0]     fr_out_port,
  input logic              lk_valid,
  input logic [VID_W-1:0]  lk_vid,
  input logic              tb_hit,
  input logic [NPORTS-1:0] tb_member,
  input logic [NPORTS-1:0] tb_tagmask,
  input logic              rs_valid,
  input logic              rs_insert,
  input logic [VID_W-1:0]  rs_vid,
  input logic              rs_strip,
  input logic              rs_drop
);
  p_lookup_follows_r2: assert property (@(posedge clk) disable iff (rst)
    fr_valid |=> lk_valid);

  p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  p_vid_carried_r5: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_vid == $past(lk_vid));

  p_drop_clean_r11: assert property (@(posedge clk) disable iff (rst)
    rs_drop |-> (!rs_insert && !rs_strip));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |-> (!rs_insert && !rs_strip && !rs_drop));
endmodule

bind vtc_port_tagger vtc_port_tagger_chk #(
  .NPORTS(NPORTS), .PW(PW), .VID_W(VID_W), .AW(AW), .DW(DW)
) u_chk (.*);

// File: tb/vtc_port_tagger_test.sv
`timescale 1ns/1ps
module vtc_port_tagger_test;
  localparam int NP = 5, PW = 3, VW = 12, AW = 8, DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          fr_valid = 1'b0, fr_tagged = 1'b0;
  logic [VW-1:0] fr_vid = '0;
  logic [PW-1:0] fr_in_port = '0, fr_out_port = '0;
  logic          lk_valid, rs_valid, rs_insert, rs_strip, rs_drop;
  logic [VW-1:0] lk_vid, rs_vid;
  logic          tb_hit;
  logic [NP-1:0] tb_member, tb_tagmask;

  vtc_port_tagger uut (.*);

  // ---- table model ----
  typedef struct packed { logic hit; logic [NP-1:0] mem; logic [NP-1:0] tag; } tent_t;
  function automatic tent_t tlook(input logic [VW-1:0] v);
    case (v)
      12'd100: return '{1'b1, 5'b00111, 5'b00101};
      12'd200: return '{1'b1, 5'b11000, 5'b01000};
      12'd300: return '{1'b1, 5'b00011, 5'b00000};
      12'd400: return '{1'b1, 5'b10101, 5'b10101};
      default: return '0;
    endcase
  endfunction

  always_comb begin
    tent_t t;
    t = tlook(lk_vid);
    tb_hit = t.hit; tb_member = t.mem; tb_tagmask = t.tag;
  end

  // ---- shadow configuration ----
  logic [1:0]    s_imode [NP];
  logic [1:0]    s_emode [NP];
  logic          s_en [NP], s_ver [NP], s_dis [NP];
  logic [VW-1:0] s_pvid [NP];

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed { logic ins; logic [VW-1:0] vid; logic strip; logic drop; } res_t;
  res_t          q_res [$];
  string         q_req [$];
  logic [VW-1:0] q_lk  [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    repeat (3) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (a == 8'h00) s_imode[p] = d[2*p +: 2];
      if (a == 8'h04) s_emode[p] = d[2*p +: 2];
      if (a == 8'h08) s_en[p] = d[p];
      if (a == 8'h0C) begin s_ver[p] = d[p]; s_dis[p] = d[8+p]; end
      if (a == 8'(64 + 4*p)) s_pvid[p] = d[VW-1:0];
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic tg, input logic [VW-1:0] v, input int ip, input int op,
                      input string req);
    logic ins, tag_eff, drop, strip, hit;
    logic [VW-1:0] evid;
    tent_t t;
    ins     = (s_imode[ip] == 2'd2) && s_en[ip];
    tag_eff = ins || tg;
    evid    = ins ? s_pvid[ip] : (tg ? v : '0);
    t       = tlook(evid);
    hit     = t.hit && tag_eff;
    drop    = s_ver[ip] && s_dis[ip] && (!tag_eff || !t.hit || !t.mem[ip]);
    case (s_emode[op])
      2'd1:    strip = tag_eff;
      2'd3:    strip = hit && !t.tag[op];
      default: strip = 1'b0;
    endcase
    if (drop) begin ins = 1'b0; strip = 1'b0; end
    q_res.push_back('{ins, evid, strip, drop});
    q_req.push_back(req);
    q_lk.push_back(evid);
    fr_valid = 1'b1; fr_tagged = tg; fr_vid = v;
    fr_in_port = PW'(ip); fr_out_port = PW'(op);
    @(negedge clk);
    fr_valid = 1'b0;
  endtask

  // ---- monitor / scoreboard ----
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (lk_valid) begin
          if (q_lk.size() == 0) chk(1'b0, "R2 unexpected lookup", 64'(lk_vid), 64'h0);
          else begin
            logic [VW-1:0] e;
            e = q_lk.pop_front();
            chk(lk_vid == e, "R5 lookup vid", 64'(lk_vid), 64'(e));
          end
        end
        if (rs_valid) begin
          res_t got;
          got = '{rs_insert, rs_vid, rs_strip, rs_drop};
          if (q_res.size() == 0) chk(1'b0, "R2 unexpected result", 64'(got), 64'h0);
          else begin
            res_t e;
            string r;
            e = q_res.pop_front();
            r = q_req.pop_front();
            chk(got == e, r, 64'(got), 64'(e));
          end
        end
      end
    end
  end

  // ---- watchdog ----
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2 watchdog expired", 64'(q_res.size()), 64'h0);
      summary();
    end
  end

  // ---- stimulus ----
  initial begin
    for (int p = 0; p < NP; p++) begin
      s_imode[p] = '0; s_emode[p] = '0; s_en[p] = 0; s_ver[p] = 0; s_dis[p] = 0; s_pvid[p] = '0;
    end
    repeat (5) @(negedge clk);
    chk(!lk_valid && !rs_valid, "R1 valids low in reset", 64'({lk_valid, rs_valid}), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!lk_valid && !rs_valid, "R1 valids low after reset", 64'({lk_valid, rs_valid}), 64'h0);

    // R1: defaults, nothing inserted, stripped or dropped
    send(1'b1, 12'd100, 0, 1, "R1 default tagged");
    send(1'b0, 12'd55,  3, 2, "R1 default untagged R5");
    repeat (3) @(negedge clk);

    // R3/R4 setup: port0 mode1, port1 mode2, port2 mode2, port4 mode3
    wr(8'h00, 32'h0000_0000 | (1 << 0) | (2 << 2) | (2 << 4) | (3 << 8));
    wr(8'h08, 32'h13);                 // enable bits 0,1,4 (port2 clear)
    wr(8'h40, 32'd100);
    wr(8'h44, 32'd200);
    wr(8'h50, 32'd400);
    send(1'b0, 12'd0,   1, 3, "R3 insert untagged");
    send(1'b1, 12'd300, 1, 3, "R3 insert over tag R5");
    send(1'b1, 12'd300, 2, 3, "R4 mode2 enable clear");
    send(1'b1, 12'd300, 0, 3, "R4 mode1 enable set");
    send(1'b0, 12'd0,   4, 3, "R4 mode3 enable set");
    repeat (3) @(negedge clk);

    // egress modes: p0=0, p1=1, p2=2, p3=3, p4=3
    wr(8'h04, (0 << 0) | (1 << 2) | (2 << 4) | (3 << 6) | (3 << 8));
    send(1'b1, 12'd300, 2, 1, "R7 strip tagged");
    send(1'b0, 12'd0,   2, 1, "R7 no strip untagged");
    send(1'b0, 12'd0,   1, 1, "R7 strip inserted");
    send(1'b1, 12'd300, 2, 2, "R6 tag-through");
    send(1'b1, 12'd300, 2, 0, "R6 disabled");
    send(1'b1, 12'd100, 3, 3, "R8 hit tagmask clear");
    send(1'b1, 12'd200, 3, 3, "R8 hit tagmask set");
    send(1'b1, 12'd500, 3, 3, "R8 miss");
    send(1'b1, 12'd400, 3, 4, "R8 hit tagmask set p4");
    send(1'b1, 12'd300, 3, 4, "R8 hit tagmask clear p4");
    repeat (3) @(negedge clk);

    // filtering: p1,p2 verify+discard, p3 verify only, p4 discard only
    wr(8'h0C, (1 << 1) | (1 << 2) | (1 << 3) | (1 << (8+1)) | (1 << (8+2)) | (1 << (8+4)));
    send(1'b1, 12'd100, 2, 3, "R9 member passes");
    send(1'b1, 12'd200, 2, 3, "R9 non-member drop R11");
    send(1'b1, 12'd777, 2, 1, "R9 miss drop R11");
    send(1'b0, 12'd0,   2, 2, "R9 untagged drop");
    send(1'b0, 12'd0,   1, 1, "R11 inserted then dropped");
    send(1'b1, 12'd777, 3, 1, "R10 verify only");
    send(1'b1, 12'd777, 4, 1, "R10 discard only");
    repeat (3) @(negedge clk);

    // R12: writes to unused addresses
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h42, 32'hFFFF_FFFF);
    send(1'b1, 12'd500, 0, 2, "R12 port0 unchanged");
    send(1'b0, 12'd0,   3, 1, "R12 port3 unchanged");
    send(1'b0, 12'd0,   1, 1, "R12 pvid unchanged");
    send(1'b1, 12'd777, 4, 3, "R12 filter unchanged");
    repeat (8) @(negedge clk);
    chk(q_res.size() == 0, "R2 all results delivered", 64'(q_res.size()), 64'h0);
    done = 1;
    summary();
  end
endmodule